// File: doc/BRIEF.md
# Memory-Mapped Serial Port Controller

This block is an asynchronous serial port that a processor drives through four byte-wide registers in a 32-byte address window. A byte written to the data register is held in a one-deep transmit buffer. The buffer moves into a shifter, which sends a low start bit, the data least significant bit first, an optional ninth bit, and a high stop bit. Every bit lasts a fixed number of clock cycles.

On the receive side the line passes through a two-stage synchroniser. Each bit is sampled three times around its middle and the majority value is kept. A completed frame lands in a receive buffer. Status flags track the transmitter state, the receiver state and receive errors. These flags, combined with per-source enable bits, drive one interrupt request line.

Software polls or takes the interrupt. It then reads the status register followed by the data register to collect a byte and clear the receive-side flags.

Top module: `mmio_serial`

## Requirements
- R1: After reset the status register (offset 0x0E) reads 0xC0, both control registers read 0x00, `txd` is 1, `irq` is 0 and `rdata` is 0.
- R2: Offset 0x0D is a fully writable control byte. Offset 0x0C stores bit 6 (ninth bit to send), bit 4 (1 = nine data bits) and bit 3 (stored only). Its bit 7 shows the last received ninth bit and ignores writes. Its other bits read 0. Offsets other than 0x0C to 0x0F read 0. Read data appears on `rdata` one cycle after the read strobe.
- R3: A transmitted frame is a low start bit, eight data bits least significant first, then (in nine-bit mode) offset 0x0C bit 6, then a high stop bit. Each bit lasts BIT_CYCLES clocks.
- R4: The transmitter starts a frame only while offset 0x0D bit 3 (mask 0x08) is 1. A byte written while it is 0 stays pending and `txd` stays high.
- R5: Status bit 7 (buffer empty) and bit 6 (transmit complete) both go to 0 when offset 0x0F is written. Bit 7 returns to 1 when the shifter takes the byte. Bit 6 returns to 1 once the shifter is idle with no byte pending.
- R6: Frames are accepted only while offset 0x0D bit 2 (mask 0x04) is 1. A received byte sets status bit 5 and is returned by a read of offset 0x0F. Its ninth bit goes to offset 0x0C bit 7.
- R7: A status read followed later by a data read clears status bits 5 to 1. A data read with no status read before it since the last clear leaves them set.
- R8: Status bit 3 (overrun) is set when a frame completes while bit 5 is still 1. The byte already in the receive buffer is kept and the new one is dropped.
- R9: Status bit 2 (noise) is set when the three samples of any bit in a frame disagree, and the majority value is stored. Status bit 1 (framing) is set when the stop bit samples low.
- R10: Status bit 4 (line idle) is set once the line has stayed high for a full frame time after a received frame.
- R11: `irq` is a register that is 1 one cycle after any of these pairs are all 1: control bit 7 and status bit 7; control bit 6 and status bit 6; control bit 5 and any of status bits 5, 3, 2, 1; control bit 4 and status bit 4. Here control means offset 0x0D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Access select for the register window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| irq | output | 1 | Registered interrupt request |

## Verification
Register reads complete one cycle after the strobe, so the bench drives each access at a falling edge and collects `rdata` at the next falling edge. A transmit frame starts on the clock after the data write takes effect. The bench decoder waits for the line to fall and samples every bit at its middle, so a small start offset does not matter.

A received frame raises its flags about three cycles after the middle of the stop bit: two synchroniser stages, the frame-done register, then the flag register. The bench reads status four cycles after it finishes driving the stop bit. That is well before the one-frame idle timeout, except in the test that waits for the idle flag on purpose.

`irq` is checked at least three cycles after the flag or enable that changes it.

// File: rtl/msc_pkg.sv
package msc_pkg;
  // Byte offsets inside the 32-byte register window
  localparam logic [4:0] OFF_CTL1 = 5'h0C;
  localparam logic [4:0] OFF_CTL2 = 5'h0D;
  localparam logic [4:0] OFF_STAT = 5'h0E;
  localparam logic [4:0] OFF_DATA = 5'h0F;

  // Control byte at OFF_CTL2
  localparam int C2_TXE_IE  = 7;
  localparam int C2_TXC_IE  = 6;
  localparam int C2_RX_IE   = 5;
  localparam int C2_IDLE_IE = 4;
  localparam int C2_TX_EN   = 3;
  localparam int C2_RX_EN   = 2;

  // Control byte at OFF_CTL1
  localparam int C1_RX9  = 7;
  localparam int C1_TX9  = 6;
  localparam int C1_NINE = 4;
  localparam int C1_KEEP = 3;

  // Status byte
  localparam int S_TXE  = 7;
  localparam int S_TXC  = 6;
  localparam int S_RXF  = 5;
  localparam int S_IDLE = 4;
  localparam int S_OVR  = 3;
  localparam int S_NOI  = 2;
  localparam int S_FRM  = 1;

  typedef struct packed {
    logic [7:0] data;
    logic       ninth;
    logic       noisy;
    logic       bad_stop;
  } rx_frame_t;
endpackage

// File: rtl/msc_tx.sv
// Transmit buffer plus shifter. BIT_CYCLES must be at least 4.
module msc_tx #(
  parameter int BIT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       nine,
  input  logic       t8,
  input  logic       load,
  input  logic [7:0] ldata,
  output logic       txd,
  output logic       buf_empty,
  output logic       idle
);
  localparam int CW = $clog2(BIT_CYCLES);

  logic [7:0]    hold;
  logic          full;
  logic          busy;
  logic [10:0]   sh;
  logic [3:0]    bidx;
  logic [3:0]    last;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      full <= 1'b0;
      busy <= 1'b0;
      sh   <= '1;
      bidx <= '0;
      last <= 4'd9;
      cyc  <= '0;
      txd  <= 1'b1;
    end else begin
      if (!busy) begin
        if (full && en) begin
          busy <= 1'b1;
          full <= 1'b0;
          sh   <= {1'b1, (nine ? t8 : 1'b1), hold, 1'b0};
          last <= nine ? 4'd10 : 4'd9;
          bidx <= '0;
          cyc  <= '0;
          txd  <= 1'b0;
        end
      end else if (cyc == CW'(BIT_CYCLES - 1)) begin
        cyc <= '0;
        if (bidx == last) begin
          busy <= 1'b0;
        end else begin
          bidx <= bidx + 4'd1;
          txd  <= sh[1];
          sh   <= {1'b1, sh[10:1]};
        end
      end else begin
        cyc <= cyc + 1'b1;
      end
      // a new byte overrides the take above; the shifter already has the old one
      if (load) begin
        hold <= ldata;
        full <= 1'b1;
      end
    end
  end

  assign buf_empty = !full;
  assign idle      = !busy && !full;

  assert_line_high_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_start_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(en));
endmodule

// File: rtl/msc_rx.sv
// Synchroniser, majority-of-three bit sampler and idle-line timer.
module msc_rx
  import msc_pkg::*;
#(
  parameter int BIT_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      nine,
  input  logic      rxd,
  output logic      done,
  output rx_frame_t frm,
  output logic      idle_hit
);
  localparam int CW   = $clog2(BIT_CYCLES);
  localparam int HALF = BIT_CYCLES / 2;
  localparam int HW   = $clog2(11 * BIT_CYCLES + 1);

  logic          s1, rs, rq;
  logic          busy;
  logic [CW-1:0] oc;
  logic [3:0]    bidx, last;
  logic [1:0]    smp;
  logic [8:0]    dsh;
  logic          nacc, nine_l, arm;
  logic [HW-1:0] hcnt, need;
  logic          fall, vote, split;

  assign fall  = rq && !rs;
  assign vote  = (smp[1] & smp[0]) | (smp[1] & rs) | (smp[0] & rs);
  assign split = !((smp[1] == smp[0]) && (smp[0] == rs));
  assign need  = nine_l ? HW'(11 * BIT_CYCLES) : HW'(10 * BIT_CYCLES);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; rs <= 1'b1; rq <= 1'b1;
      busy <= 1'b0; oc <= '0; bidx <= '0; last <= 4'd9;
      smp <= '0; dsh <= '0; nacc <= 1'b0; nine_l <= 1'b0;
      arm <= 1'b0; hcnt <= '0;
      done <= 1'b0; idle_hit <= 1'b0; frm <= '0;
    end else begin
      s1 <= rxd;
      rs <= s1;
      rq <= rs;
      done     <= 1'b0;
      idle_hit <= 1'b0;
      // idle-line timer, armed by each completed frame
      if (busy || !en || !rs) begin
        hcnt <= '0;
      end else if (arm) begin
        if (hcnt == need - 1'b1) begin
          idle_hit <= 1'b1;
          arm      <= 1'b0;
          hcnt     <= '0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
      if (!busy) begin
        if (en && fall) begin
          busy   <= 1'b1;
          oc     <= CW'(1);
          bidx   <= '0;
          nacc   <= 1'b0;
          nine_l <= nine;
          last   <= nine ? 4'd10 : 4'd9;
        end
      end else if (!en) begin
        busy <= 1'b0;
      end else begin
        oc <= (oc == CW'(BIT_CYCLES - 1)) ? '0 : oc + 1'b1;
        if (oc == CW'(BIT_CYCLES - 1)) bidx <= bidx + 4'd1;
        if (oc == CW'(HALF - 1) || oc == CW'(HALF)) smp <= {smp[0], rs};
        if (oc == CW'(HALF + 1)) begin
          nacc <= nacc | split;
          if (bidx == 4'd0) begin
            if (vote) busy <= 1'b0;          // false start
          end else if (bidx == last) begin
            busy         <= 1'b0;
            done         <= 1'b1;
            arm          <= 1'b1;
            frm.data     <= nine_l ? dsh[7:0] : dsh[8:1];
            frm.ninth    <= nine_l & dsh[8];
            frm.noisy    <= nacc | split;
            frm.bad_stop <= !vote;
          end else begin
            dsh <= {vote, dsh[8:1]};
          end
        end
      end
    end
  end

  assert_frame_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(en));
  assert_idle_only_when_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    idle_hit |-> ($past(rs) && !busy));
endmodule

// File: rtl/mmio_serial.sv
module mmio_serial
  import msc_pkg::*;
#(
  parameter int BIT_CYCLES = 8,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  logic [4:0] off;
  logic       wr_c1, wr_c2, wr_dat, rd_any, rd_st, rd_dat, clr;
  logic [7:0] ctl2, rbuf, stat_b, ctl1_b, rd_mux;
  logic       t8_r, nine_r, keep_r, r8_r;
  logic       rxf, idle_f, ovr, noi, frm_e, seen;
  logic       tx_empty, tx_idle;
  logic       rx_done, idle_hit;
  rx_frame_t  rfrm;

  assign off    = addr[4:0];
  assign wr_c1  = sel && wr_en && (off == OFF_CTL1);
  assign wr_c2  = sel && wr_en && (off == OFF_CTL2);
  assign wr_dat = sel && wr_en && (off == OFF_DATA);
  assign rd_any = sel && rd_en;
  assign rd_st  = rd_any && (off == OFF_STAT);
  assign rd_dat = rd_any && (off == OFF_DATA);
  assign clr    = rd_dat && seen;

  msc_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
    .clk(clk), .rst(rst), .en(ctl2[C2_TX_EN]), .nine(nine_r), .t8(t8_r),
    .load(wr_dat), .ldata(wdata), .txd(txd), .buf_empty(tx_empty), .idle(tx_idle)
  );

  msc_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
    .clk(clk), .rst(rst), .en(ctl2[C2_RX_EN]), .nine(nine_r), .rxd(rxd),
    .done(rx_done), .frm(rfrm), .idle_hit(idle_hit)
  );

  always_comb begin
    stat_b          = '0;
    stat_b[S_TXE]   = tx_empty;
    stat_b[S_TXC]   = tx_idle;
    stat_b[S_RXF]   = rxf;
    stat_b[S_IDLE]  = idle_f;
    stat_b[S_OVR]   = ovr;
    stat_b[S_NOI]   = noi;
    stat_b[S_FRM]   = frm_e;
    ctl1_b          = '0;
    ctl1_b[C1_RX9]  = r8_r;
    ctl1_b[C1_TX9]  = t8_r;
    ctl1_b[C1_NINE] = nine_r;
    ctl1_b[C1_KEEP] = keep_r;
    case (off)
      OFF_CTL1: rd_mux = ctl1_b;
      OFF_CTL2: rd_mux = ctl2;
      OFF_STAT: rd_mux = stat_b;
      OFF_DATA: rd_mux = rbuf;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl2 <= '0; t8_r <= 1'b0; nine_r <= 1'b0; keep_r <= 1'b0; r8_r <= 1'b0;
      rbuf <= '0; rdata <= '0; irq <= 1'b0;
      rxf <= 1'b0; idle_f <= 1'b0; ovr <= 1'b0; noi <= 1'b0; frm_e <= 1'b0;
      seen <= 1'b0;
    end else begin
      if (wr_c2) ctl2 <= wdata;
      if (wr_c1) begin
        t8_r   <= wdata[C1_TX9];
        nine_r <= wdata[C1_NINE];
        keep_r <= wdata[C1_KEEP];
      end
      if (rd_any) rdata <= rd_mux;
      if (rd_st) seen <= rxf | idle_f | ovr | noi | frm_e;
      if (clr) begin
        rxf <= 1'b0; idle_f <= 1'b0; ovr <= 1'b0; noi <= 1'b0; frm_e <= 1'b0;
        seen <= 1'b0;
      end
      if (idle_hit) idle_f <= 1'b1;
      if (rx_done) begin
        if (rxf && !clr) begin
          ovr <= 1'b1;
        end else begin
          rbuf  <= rfrm.data;
          r8_r  <= rfrm.ninth;
          rxf   <= 1'b1;
          noi   <= rfrm.noisy | (noi & !clr);
          frm_e <= rfrm.bad_stop | (frm_e & !clr);
        end
      end
      irq <= (ctl2[C2_TXE_IE] & tx_empty)
           | (ctl2[C2_TXC_IE] & tx_idle)
           | (ctl2[C2_RX_IE] & (rxf | ovr | noi | frm_e))
           | (ctl2[C2_IDLE_IE] & idle_f);
    end
  end

  assert_overrun_keeps_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rxf && !clr) |=> (ovr && rbuf == $past(rbuf)));
  assert_rx_flag_drops_on_data_read_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rxf) |-> $past(rd_dat && seen));
  assert_irq_quiet_without_enables_R11: assert property (@(posedge clk) disable iff (rst)
    (ctl2[7:4] == 4'b0) |=> !irq);
  assert_write_takes_buffer_R5: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> (!tx_empty && !tx_idle));
endmodule

// File: tb/sim_mmio_serial.sv
module sim_mmio_serial;
  localparam int CLK_PERIOD = 10;
  localparam int B = 8;

  logic       clk = 1'b0, rst = 1'b1, sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rxd = 1'b1;
  wire  [7:0] rdata;
  wire        txd, irq;

  int checks = 0, fails = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_serial #(.BIT_CYCLES(B), .ADDR_W(5)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st(bit e, bit c, bit f, bit i, bit o, bit n, bit fr);
    return {e, c, f, i, o, n, fr, 1'b0};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd_en = 1; addr = a;
    @(negedge clk); sel = 0; rd_en = 0; d = rdata;
  endtask

  task automatic send(input logic [7:0] d, input bit ninth, input bit nine,
                      input bit bad_stop, input int noisy_bit);
    logic [10:0] fb;
    int n;
    fb = '1; fb[0] = 1'b0; fb[8:1] = d;
    if (nine) begin fb[9] = ninth; fb[10] = !bad_stop; n = 11; end
    else begin fb[9] = !bad_stop; n = 10; end
    for (int b = 0; b < n; b++)
      for (int o = 0; o < B; o++) begin
        @(negedge clk);
        rxd = (b == noisy_bit && o == B/2) ? ~fb[b] : fb[b];
      end
    @(negedge clk); rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic grab(input bit nine, output logic [8:0] v, output logic stop);
    int t;
    t = 0; v = '0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    repeat (B/2) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      repeat (B) @(negedge clk);
      v[i] = txd;
    end
    repeat (B) @(negedge clk);
    stop = txd;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog (run incomplete) actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r, d;
    logic [8:0] v;
    logic       stp;
    bit         nn, b9;
    int         lowseen;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", {8'h0, rdata}, 16'h0);
    check("R1 txd", {15'h0, txd}, 16'h1);
    check("R1 irq", {15'h0, irq}, 16'h0);
    rd(5'h0E, r); check("R1 status", {8'h0, r}, 16'h00C0);
    rd(5'h0D, r); check("R1 ctl2", {8'h0, r}, 16'h0);
    rd(5'h0C, r); check("R1 ctl1", {8'h0, r}, 16'h0);

    // R2 register map
    wr(5'h0C, 8'hFF); rd(5'h0C, r); check("R2 ctl1 writable bits", {8'h0, r}, 16'h0058);
    wr(5'h0D, 8'h03); rd(5'h0D, r); check("R2 ctl2 readback", {8'h0, r}, 16'h0003);
    rd(5'h00, r); check("R2 unmapped offset", {8'h0, r}, 16'h0);
    rd(5'h1F, r); check("R2 unmapped offset", {8'h0, r}, 16'h0);
    wr(5'h0C, 8'h00); wr(5'h0D, 8'h00);

    // R4 pending byte with transmitter off
    wr(5'h0F, 8'hA5);
    rd(5'h0E, r); check("R5 write clears empty and complete", {8'h0, r}, {8'h0, st(0,0,0,0,0,0,0)});
    lowseen = 0;
    for (int i = 0; i < 30 * B; i++) begin @(negedge clk); if (txd !== 1'b1) lowseen++; end
    check("R4 line stays high while disabled", lowseen[15:0], 16'h0);
    wr(5'h0D, 8'h08);
    fork
      grab(1'b0, v, stp);
      begin repeat (3) @(negedge clk); rd(5'h0E, r);
            check("R5 empty while shifting", {8'h0, r}, {8'h0, st(1,0,0,0,0,0,0)}); end
    join
    check("R3 R4 sent byte", {7'h0, v}, 16'h00A5);
    check("R3 stop bit", {15'h0, stp}, 16'h1);
    repeat (B) @(negedge clk);
    rd(5'h0E, r); check("R5 complete after frame", {8'h0, r}, 16'h00C0);

    // R3 random frames, both lengths
    for (int k = 0; k < 6; k++) begin
      nn = 1'($urandom()); b9 = 1'($urandom()); d = 8'($urandom());
      wr(5'h0C, {1'b0, b9, 1'b0, nn, 4'b0});
      wr(5'h0F, d);
      grab(nn, v, stp);
      check("R3 frame data", {7'h0, v}, {7'h0, (nn ? b9 : 1'b0), d});
      check("R3 stop bit", {15'h0, stp}, 16'h1);
      repeat (B) @(negedge clk);
    end
    wr(5'h0C, 8'h00);

    // R6 receiver disabled
    wr(5'h0D, 8'h08);
    send(8'h3C, 1'b0, 1'b0, 1'b0, -1);
    rd(5'h0E, r); check("R6 frame ignored while disabled", {8'h0, r}, 16'h00C0);
    wr(5'h0D, 8'h0C);

    // R6 R7 random receive
    for (int k = 0; k < 6; k++) begin
      nn = 1'($urandom()); b9 = 1'($urandom()); d = 8'($urandom());
      wr(5'h0C, {3'b0, nn, 4'b0});
      send(d, b9, nn, 1'b0, -1);
      rd(5'h0E, r); check("R6 byte waiting", {8'h0, r}, {8'h0, st(1,1,1,0,0,0,0)});
      rd(5'h0C, r); check("R6 ninth bit", {8'h0, r}, {8'h0, (nn & b9), 2'b0, nn, 4'b0});
      rd(5'h0F, r); check("R6 received byte", {8'h0, r}, {8'h0, d});
      rd(5'h0E, r); check("R7 cleared by sequence", {8'h0, r}, 16'h00C0);
    end
    wr(5'h0C, 8'h00);

    // R7 data read alone does not clear
    send(8'h96, 1'b0, 1'b0, 1'b0, -1);
    rd(5'h0F, r); check("R7 byte", {8'h0, r}, 16'h0096);
    rd(5'h0E, r); check("R7 no clear without status read", {8'h0, r}, 16'h00E0);
    rd(5'h0F, r); rd(5'h0E, r); check("R7 clear after status read", {8'h0, r}, 16'h00C0);

    // R8 overrun
    send(8'h11, 1'b0, 1'b0, 1'b0, -1);
    send(8'h22, 1'b0, 1'b0, 1'b0, -1);
    rd(5'h0E, r); check("R8 overrun flag", {8'h0, r}, {8'h0, st(1,1,1,0,1,0,0)});
    rd(5'h0F, r); check("R8 first byte kept", {8'h0, r}, 16'h0011);
    rd(5'h0E, r); check("R8 cleared", {8'h0, r}, 16'h00C0);

    // R9 noise and framing
    send(8'h5A, 1'b0, 1'b0, 1'b0, 3);
    rd(5'h0E, r); check("R9 noise flag", {8'h0, r}, {8'h0, st(1,1,1,0,0,1,0)});
    rd(5'h0F, r); check("R9 majority value", {8'h0, r}, 16'h005A);
    send(8'h77, 1'b0, 1'b0, 1'b1, -1);
    rd(5'h0E, r); check("R9 framing flag", {8'h0, r}, {8'h0, st(1,1,1,0,0,0,1)});
    rd(5'h0F, r); check("R9 byte with bad stop", {8'h0, r}, 16'h0077);
    rd(5'h0E, r); check("R9 cleared", {8'h0, r}, 16'h00C0);

    // R10 idle line, R11 idle interrupt
    repeat (12 * B) @(negedge clk);
    rd(5'h0E, r); check("R10 idle flag", {8'h0, r}, {8'h0, st(1,1,0,1,0,0,0)});
    wr(5'h0D, 8'h1C); repeat (3) @(negedge clk);
    check("R11 idle interrupt", {15'h0, irq}, 16'h1);
    rd(5'h0F, r); repeat (3) @(negedge clk);
    check("R11 irq drops after clear", {15'h0, irq}, 16'h0);

    // R11 other sources
    wr(5'h0D, 8'h8C); repeat (3) @(negedge clk);
    check("R11 empty interrupt", {15'h0, irq}, 16'h1);
    wr(5'h0D, 8'h4C); repeat (3) @(negedge clk);
    check("R11 complete interrupt", {15'h0, irq}, 16'h1);
    wr(5'h0D, 8'h2C); repeat (3) @(negedge clk);
    check("R11 receive interrupt idle", {15'h0, irq}, 16'h0);
    send(8'hC3, 1'b0, 1'b0, 1'b0, -1);
    check("R11 receive interrupt", {15'h0, irq}, 16'h1);
    rd(5'h0E, r); rd(5'h0F, r); repeat (3) @(negedge clk);
    check("R11 receive interrupt cleared", {15'h0, irq}, 16'h0);
    wr(5'h0D, 8'h80); wr(5'h0F, 8'h01); repeat (3) @(negedge clk);
    check("R11 no empty interrupt with byte pending", {15'h0, irq}, 16'h0);
    wr(5'h0D, 8'h00); repeat (3) @(negedge clk);
    check("R11 all enables off", {15'h0, irq}, 16'h0);

    ended = 1'b1;
    finish_run();
  end
endmodule